// File: doc/BRIEF.md
# Software Store Unlock Detector

This block sits beside the host port of a byte-wide asynchronous memory with a nonvolatile shadow. It watches completed host cycles and recognizes a fixed six-read unlock key on the 13-bit address bus. When the key has been read in full and in order, it raises a one-cycle request that tells the store/recall controller to begin a store.

Each completed read or write arrives as a one-cycle strobe together with the captured address. The read may have been ended by either chip enable or output enable. The detector keeps only a step count. A read that matches the next key address advances the count. A read of any other address aborts the sequence, and so does any write. While the controller reports busy, the detector ignores every strobe. The request does not depend on whether the array was written since the last nonvolatile cycle. Read data is never altered.

Top module: `sw_store_unlock`

## Requirements
- R1: The key is six reads of the addresses 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and 0x0F0F, in that order. After all six, `store_start_o` is high. No earlier read of the key raises it, and idle cycles between the reads have no effect.
- R2: `store_start_o` is high for exactly one clock cycle. That cycle follows the clock edge that samples the sixth matching read strobe.
- R3: A read of any address other than the next key address aborts the sequence. This includes a key address read out of order. After an abort, reading the rest of the key raises no request.
- R4: A write strobe aborts the sequence. If a write strobe and a read strobe arrive in the same cycle, the write wins, and no request is raised even when the read would have completed the key.
- R5: A read of 0x0000 part-way through the sequence restarts it at step one. Five further key reads starting at 0x1555 then complete it.
- R6: While `busy_i` is high, read and write strobes are ignored. They neither advance nor abort the sequence and raise no request.
- R7: Reset clears progress. Key reads made before reset do not count toward a key completed after reset, and `store_start_o` is low during reset.
- R8: After a completed key the detector is back at the start. A second full key raises a second request, and a request needs no prior write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_done_i | input | 1 | One-cycle strobe: a host read cycle completed |
| wr_done_i | input | 1 | One-cycle strobe: a host write cycle completed |
| addr_i | input | 13 | Address captured for the completed cycle |
| busy_i | input | 1 | High while a store or recall is in progress |
| store_start_o | output | 1 | One-cycle store-start request |

## Verification
The only state is the step count. A wrong count shows at the port only when the sequence reaches its end. A missing request, an extra request or a request one read early or late all appear in the cycle after the strobe that should or should not have completed the key. The scenarios therefore finish the key after each abort, restart, busy window and reset, so that any error in the count becomes visible within a few cycles.

// File: rtl/sw_unlock_pkg.sv
package sw_unlock_pkg;
  localparam int ADDR_W  = 13;
  localparam int KEY_LEN = 6;
  localparam int STEP_W  = $clog2(KEY_LEN);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [STEP_W-1:0] step_t;

  function automatic addr_t key_at(input int idx);
    case (idx)
      0:       return addr_t'(13'h0000);
      1:       return addr_t'(13'h1555);
      2:       return addr_t'(13'h0AAA);
      3:       return addr_t'(13'h1FFF);
      4:       return addr_t'(13'h10F0);
      default: return addr_t'(13'h0F0F);
    endcase
  endfunction
endpackage

// File: rtl/sw_unlock_key_match.sv
module sw_unlock_key_match
  import sw_unlock_pkg::*;
(
  input  addr_t addr_i,
  input  step_t step_i,
  output logic  hit_cur_o,
  output logic  hit_first_o,
  output logic  last_o
);
  logic [KEY_LEN-1:0] hit_vec;

  for (genvar g = 0; g < KEY_LEN; g++) begin : g_cmp
    assign hit_vec[g] = (addr_i == key_at(g));
  end

  always_comb begin
    hit_cur_o = 1'b0;
    for (int i = 0; i < KEY_LEN; i++) begin
      if (step_t'(i) == step_i) hit_cur_o = hit_vec[i];
    end
  end

  assign hit_first_o = hit_vec[0];
  assign last_o      = (step_i == step_t'(KEY_LEN - 1));
endmodule

// File: rtl/sw_unlock_tracker.sv
module sw_unlock_tracker
  import sw_unlock_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rd_ev_i,
  input  logic  wr_ev_i,
  input  logic  hit_cur_i,
  input  logic  hit_first_i,
  input  logic  last_i,
  output step_t step_o,
  output logic  done_o
);
  step_t step_q;
  logic  done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= rd_ev_i && !wr_ev_i && hit_cur_i && last_i;
      if (wr_ev_i) begin
        step_q <= '0;
      end else if (rd_ev_i) begin
        if (hit_cur_i) step_q <= last_i ? '0 : step_t'(step_q + 1'b1);
        else           step_q <= hit_first_i ? step_t'(1) : '0;
      end
    end
  end

  assign step_o = step_q;
  assign done_o = done_q;
endmodule

// File: rtl/sw_store_unlock.sv
module sw_store_unlock
  import sw_unlock_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_done_i,
  input  logic              wr_done_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  output logic              store_start_o
);
  logic  rd_ev, wr_ev, hit_cur, hit_first, last;
  step_t step_w;

  assign rd_ev = rd_done_i && !busy_i;
  assign wr_ev = wr_done_i && !busy_i;

  sw_unlock_key_match u_match (
    .addr_i     (addr_i),
    .step_i     (step_w),
    .hit_cur_o  (hit_cur),
    .hit_first_o(hit_first),
    .last_o     (last)
  );

  sw_unlock_tracker u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_ev_i    (rd_ev),
    .wr_ev_i    (wr_ev),
    .hit_cur_i  (hit_cur),
    .hit_first_i(hit_first),
    .last_i     (last),
    .step_o     (step_w),
    .done_o     (store_start_o)
  );
endmodule

// File: rtl/sw_store_unlock_chk.sv
module sw_store_unlock_chk
  import sw_unlock_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_done_i,
  input logic              wr_done_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              busy_i,
  input logic              store_start_o,
  input step_t             step_w
);
  logic rd_ok, wr_ok, off_key;
  assign rd_ok   = rd_done_i && !busy_i && !wr_done_i;
  assign wr_ok   = wr_done_i && !busy_i;
  assign off_key = addr_i != 13'h0000 && addr_i != 13'h1555 && addr_i != 13'h0AAA &&
                   addr_i != 13'h1FFF && addr_i != 13'h10F0 && addr_i != 13'h0F0F;

  assert_pulse_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_start_o |=> !store_start_o);
  assert_pulse_after_last_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_start_o |-> $past(rd_ok && addr_i == 13'h0F0F && step_w == step_t'(KEY_LEN - 1)));
  assert_off_key_abort_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ok && off_key) |=> (step_w == '0 && !store_start_o));
  assert_write_abort_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> (step_w == '0 && !store_start_o));
  assert_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ok && addr_i == 13'h0000) |=> step_w == step_t'(1));
  assert_busy_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(step_w) && !store_start_o));
  assert_step_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_w < step_t'(KEY_LEN));
endmodule

bind sw_store_unlock sw_store_unlock_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_done_i    (rd_done_i),
  .wr_done_i    (wr_done_i),
  .addr_i       (addr_i),
  .busy_i       (busy_i),
  .store_start_o(store_start_o),
  .step_w       (step_w)
);

// File: tb/sw_store_unlock_bench.sv
module sw_store_unlock_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd = 1'b0, wr = 1'b0, busy = 1'b0;
  logic [12:0] addr = '0;
  logic        start;
  int          checks = 0, fails = 0, pulses = 0;
  logic        prev_start = 1'b0;

  localparam logic [12:0] KEY [6] = '{13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0, 13'h0F0F};

  always #4 clk = ~clk;

  sw_store_unlock u_sw_store_unlock (
    .clk_i(clk), .rst_ni(rst_n), .rd_done_i(rd), .wr_done_i(wr),
    .addr_i(addr), .busy_i(busy), .store_start_o(start)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // width and count monitor, sampled at falling edges
  always @(negedge clk) begin
    if (start && prev_start) check(1'b0, "R2 width", 2, 1);
    if (start) pulses++;
    prev_start <= start;
  end

  // one strobe cycle; returns the output seen one edge later
  task automatic strobe(input bit r, input bit w, input logic [12:0] a, output bit got);
    @(negedge clk);
    rd = r; wr = w; addr = a;
    @(negedge clk);
    rd = 0; wr = 0;
    got = start;
  endtask

  task automatic rd_key(input int from, input int to, input string req, input bit last_exp);
    bit got;
    for (int i = from; i <= to; i++) begin
      strobe(1, 0, KEY[i], got);
      check(got == ((i == to) ? last_exp : 1'b0), req, got, (i == to) ? last_exp : 0);
    end
  endtask

  task automatic t_reset();
    check(start == 1'b0, "R7 reset", start, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check(start == 1'b0, "R7 after reset", start, 0);
  endtask

  task automatic t_full();
    int p0 = pulses;
    bit got;
    rd_key(0, 2, "R1", 0);
    repeat (3) @(negedge clk);
    rd_key(3, 5, "R1", 1);
    @(negedge clk);
    check(start == 1'b0, "R2 one cycle", start, 0);
    rd_key(0, 5, "R8 repeat", 1);
    repeat (2) @(negedge clk);
    check(pulses - p0 == 2, "R8 pulse count", pulses - p0, 2);
    strobe(1, 0, KEY[5], got);
    check(got == 1'b0, "R8 idle after done", got, 0);
  endtask

  task automatic t_mismatch();
    bit got;
    rd_key(0, 2, "R3", 0);
    strobe(1, 0, 13'h0123, got);
    rd_key(3, 5, "R3 after abort", 0);
    rd_key(0, 1, "R3", 0);
    strobe(1, 0, KEY[3], got);
    rd_key(2, 5, "R3 out of order", 0);
    rd_key(0, 5, "R3 recovery", 1);
  endtask

  task automatic t_write();
    bit got;
    rd_key(0, 3, "R4", 0);
    strobe(0, 1, KEY[4], got);
    rd_key(4, 5, "R4 after write", 0);
    rd_key(0, 4, "R4", 0);
    strobe(1, 1, KEY[5], got);
    check(got == 1'b0, "R4 same-cycle write", got, 0);
    rd_key(0, 5, "R4 recovery", 1);
  endtask

  task automatic t_restart();
    bit got;
    rd_key(0, 2, "R5", 0);
    strobe(1, 0, KEY[0], got);
    rd_key(1, 5, "R5 restart", 1);
    strobe(1, 0, KEY[0], got);
    rd_key(0, 5, "R5 double first", 1);
  endtask

  task automatic t_busy();
    bit got;
    rd_key(0, 2, "R6", 0);
    busy = 1;
    strobe(1, 0, 13'h1234, got);
    check(got == 1'b0, "R6 busy read", got, 0);
    strobe(0, 1, 13'h0000, got);
    check(got == 1'b0, "R6 busy write", got, 0);
    busy = 0;
    rd_key(3, 4, "R6", 0);
    busy = 1;
    strobe(1, 0, KEY[5], got);
    check(got == 1'b0, "R6 busy last", got, 0);
    busy = 0;
    rd_key(5, 5, "R6 resume", 1);
  endtask

  task automatic t_reset_mid();
    rd_key(0, 2, "R7", 0);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check(start == 1'b0, "R7 in reset", start, 0);
    rst_n = 1;
    rd_key(3, 5, "R7 stale progress", 0);
    rd_key(0, 5, "R7 fresh key", 1);
  endtask

  initial begin
    t_reset();
    t_full();
    t_mismatch();
    t_write();
    t_restart();
    t_busy();
    t_reset_mid();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule